// File: doc/BRIEF.md
# Threshold-Pruned Four-State Viterbi Decoder

This block decodes a hard-decision stream protected by a rate one-half convolutional code with two memory stages, so the trellis holds four states. Each cycle with `in_valid` high delivers one received pair of coded bits. The block scores every branch by Hamming distance and runs add-compare-select into each state. It then keeps only the states whose new metric lies below the previous step's best metric plus a threshold. That threshold starts each step at a configured value and is lowered in steps of two while too many states would survive. If the threshold reaches its floor and the survivor count is still too high, states are ranked by counting and comparing, with no sort, and only the best ones are kept.

Survivor histories live in a register-exchange array. Once that array has filled, each accepted symbol produces one decoded bit, taken from the oldest position of the best surviving state. Metrics saturate, and they are rebased whenever the best metric enters the upper half of its range. The live-state mask, the threshold finally used and the best metric are brought out, so the pruning decisions can be seen at the ports.

Top module: `avd_decoder`

## Requirements
- R1: After reset, only state 0 is live (`live_mask` = 0001), `best_metric` is 0, `thr_used` equals T_INIT and `out_valid` is low.
- R2: State s = {s1,s0} with input u emits the pair {u^s1^s0, u^s0} (sym[1] first) and moves to state {u,s1}. A candidate metric is the predecessor metric plus the Hamming distance to `in_sym`, saturating at 2^MW-1.
- R3: A state survives only if its new metric is strictly below dm + T. Here dm is the lowest metric among the states live before the step.
- R4: Each step starts from T = T_INIT. While the number of passing states is NMAX or more, T drops by 2, but never below 2. `thr_used` shows the value finally applied.
- R5: If NMAX or more states still pass at the lowest threshold, only the NMAX-1 best passing states are kept. Best means lowest metric, with the lower state index winning a tie.
- R6: When both predecessors of a state are live, the lower candidate metric wins. On equal metrics the lower-numbered predecessor wins.
- R7: After every step at least one and at most NMAX-1 states are live.
- R8: When dm is 2^(MW-1) or more, dm is subtracted from every new metric. `best_metric` shows the lowest metric among the kept states after that subtraction.
- R9: From the DEPTH-th accepted symbol onward, `out_valid` is high for one cycle after each accepted symbol. `out_bit` is then the oldest history bit of the best kept state (lowest metric, lower index on a tie). On an error-free stream from reset, it equals the bit encoded DEPTH-1 symbols earlier.
- R10: A cycle with `in_valid` low changes no metric, mask or history, and `out_valid` is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received pair is present this cycle |
| in_sym | input | 2 | Received pair: bit 1 is the first generator, bit 0 the second |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded information bit |
| live_mask | output | 4 | States kept by the last step, bit n for state n |
| thr_used | output | TW | Threshold applied in the last step |
| best_metric | output | MW | Lowest kept metric after the last step |

## Verification
Metric rebasing and the ranking cap at the threshold floor can act in the same step. The cap then ranks metrics that are about to be rebased, and the best-state choice for the output must use the rebased values. A long stretch of random received pairs drives dm past mid-range while several states sit within one of the minimum, so both actions occur together. Every step's mask, threshold, best metric and output bit is compared against an arithmetic model in the bench, which selects the kept states by repeated minimum-picking rather than by rank counting.

// File: rtl/avd_pkg.sv
package avd_pkg;
  localparam int NS = 4;

  // coded pair leaving state s on input u: {g=111, g=101}
  function automatic logic [1:0] code_pair(input logic [1:0] s, input logic u);
    return {u ^ s[1] ^ s[0], u ^ s[0]};
  endfunction

  function automatic logic [1:0] hdist(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {1'b0, x[1]} + {1'b0, x[0]};
  endfunction
endpackage

// File: rtl/avd_acs.sv
module avd_acs
  import avd_pkg::*;
#(
  parameter int MW  = 8,
  parameter int TGT = 0
) (
  input  logic [1:0]    sym,
  input  logic [MW-1:0] pm_lo,
  input  logic [MW-1:0] pm_hi,
  input  logic          v_lo,
  input  logic          v_hi,
  output logic [MW-1:0] nm,
  output logic          nv,
  output logic          sel_hi
);
  localparam logic [1:0] PLO = 2'(2 * (TGT % 2));
  localparam logic [1:0] PHI = 2'(2 * (TGT % 2) + 1);
  localparam logic       U   = 1'(TGT / 2);

  function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] a, input logic [1:0] d);
    logic [MW:0] s;
    s = {1'b0, a} + {{(MW-1){1'b0}}, d};
    return s[MW] ? '1 : s[MW-1:0];
  endfunction

  logic [MW-1:0] cand_lo, cand_hi;

  assign cand_lo = sat_add(pm_lo, hdist(code_pair(PLO, U), sym));
  assign cand_hi = sat_add(pm_hi, hdist(code_pair(PHI, U), sym));
  // R6: lower metric wins, tie goes to the lower predecessor
  assign sel_hi  = v_hi && (!v_lo || (cand_hi < cand_lo));
  assign nm      = sel_hi ? cand_hi : cand_lo;
  assign nv      = v_lo | v_hi;
endmodule

// File: rtl/avd_prune.sv
module avd_prune
  import avd_pkg::*;
#(
  parameter int MW     = 8,
  parameter int NMAX   = 3,
  parameter int T_INIT = 6,
  parameter int TW     = 4
) (
  input  logic [NS-1:0][MW-1:0] nm,
  input  logic [NS-1:0]         nv,
  input  logic [MW-1:0]         dm,
  output logic [NS-1:0]         keep,
  output logic [TW-1:0]         thr,
  output logic                  shrink_evt,
  output logic                  cap_evt
);
  localparam int TMIN = 2;
  localparam int NTRY = (T_INIT - TMIN) / 2 + 1;
  localparam int CW   = $clog2(NS + 1);

  function automatic logic [CW-1:0] popc(input logic [NS-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < NS; i++) c = c + CW'(m[i]);
    return c;
  endfunction

  logic [NTRY-1:0][NS-1:0] pass_k;
  logic [NTRY-1:0]         under_k;

  // every threshold candidate evaluated in parallel (R3, R4)
  for (genvar k = 0; k < NTRY; k++) begin : g_try
    localparam logic [MW:0] THR_K = (MW+1)'(T_INIT - 2 * k);
    for (genvar n = 0; n < NS; n++) begin : g_st
      assign pass_k[k][n] = nv[n] && ({1'b0, nm[n]} < ({1'b0, dm} + THR_K));
    end
    assign under_k[k] = popc(pass_k[k]) < CW'(NMAX);
  end

  int            pick;
  logic          hit;
  logic [NS-1:0] pass_sel;
  int            rk;

  always_comb begin
    pick = NTRY - 1;
    hit  = 1'b0;
    for (int k = 0; k < NTRY; k++) begin
      if (!hit && under_k[k]) begin
        pick = k;
        hit  = 1'b1;
      end
    end
    pass_sel = pass_k[pick];
    thr      = TW'(T_INIT - 2 * pick);
    // R5: compare-and-count rank used only when the floor is not enough
    for (int n = 0; n < NS; n++) begin
      rk = 0;
      for (int m = 0; m < NS; m++) begin
        if (pass_sel[m] && (m != n) &&
            ((nm[m] < nm[n]) || ((nm[m] == nm[n]) && (m < n))))
          rk = rk + 1;
      end
      keep[n] = pass_sel[n] && (hit || (rk < NMAX - 1));
    end
    cap_evt    = !hit;
    shrink_evt = !hit || (pick != 0);
  end
endmodule

// File: rtl/avd_survivor.sv
module avd_survivor
  import avd_pkg::*;
#(
  parameter int DEPTH = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [NS-1:0] sel_hi,
  input  logic [1:0]    best_idx,
  output logic          out_valid,
  output logic          out_bit
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [NS-1:0][DEPTH-1:0] path, path_nx;
  logic [CNTW-1:0]          seen;
  logic                     full;

  for (genvar n = 0; n < NS; n++) begin : g_xchg
    localparam logic P1 = 1'(n % 2);
    localparam logic U  = 1'(n / 2);
    assign path_nx[n] = {path[{P1, sel_hi[n]}][DEPTH-2:0], U};
  end

  assign full = seen >= CNTW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      path      <= '0;
      seen      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (step) begin
      path      <= path_nx;
      if (seen != CNTW'(DEPTH)) seen <= seen + 1'b1;
      out_valid <= full;
      if (full) out_bit <= path_nx[best_idx][DEPTH-1];
    end else begin
      out_valid <= 1'b0;
    end
  end

  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(step));
endmodule

// File: rtl/avd_decoder.sv
module avd_decoder
  import avd_pkg::*;
#(
  parameter int MW     = 8,
  parameter int DEPTH  = 15,
  parameter int NMAX   = 3,
  parameter int T_INIT = 6,
  parameter int TW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_sym,
  output logic          out_valid,
  output logic          out_bit,
  output logic [NS-1:0] live_mask,
  output logic [TW-1:0] thr_used,
  output logic [MW-1:0] best_metric
);
  localparam int TFLOOR = T_INIT - 2 * ((T_INIT - 2) / 2);

  logic [NS-1:0][MW-1:0] pm, nm, nm_adj;
  logic [NS-1:0]         live, nv, sel_hi, keep;
  logic [MW-1:0]         dm;
  logic [TW-1:0]         thr;
  logic [1:0]            best_idx;
  logic                  step, norm_evt, shrink_evt, cap_evt, bfound;

  assign step = in_valid;

  always_comb begin
    dm = '1;
    for (int s = 0; s < NS; s++)
      if (live[s] && (pm[s] < dm)) dm = pm[s];
  end

  for (genvar n = 0; n < NS; n++) begin : g_acs
    avd_acs #(.MW(MW), .TGT(n)) u_acs (
      .sym   (in_sym),
      .pm_lo (pm[2 * (n % 2)]),
      .pm_hi (pm[2 * (n % 2) + 1]),
      .v_lo  (live[2 * (n % 2)]),
      .v_hi  (live[2 * (n % 2) + 1]),
      .nm    (nm[n]),
      .nv    (nv[n]),
      .sel_hi(sel_hi[n])
    );
  end

  avd_prune #(.MW(MW), .NMAX(NMAX), .T_INIT(T_INIT), .TW(TW)) u_prune (
    .nm        (nm),
    .nv        (nv),
    .dm        (dm),
    .keep      (keep),
    .thr       (thr),
    .shrink_evt(shrink_evt),
    .cap_evt   (cap_evt)
  );

  // R8: rebase once dm has reached the upper half
  assign norm_evt = dm[MW-1];
  for (genvar n = 0; n < NS; n++) begin : g_norm
    assign nm_adj[n] = norm_evt ? (nm[n] - dm) : nm[n];
  end

  always_comb begin
    best_idx = 2'd0;
    bfound   = 1'b0;
    for (int n = 0; n < NS; n++) begin
      if (keep[n] && (!bfound || (nm_adj[n] < nm_adj[best_idx]))) begin
        best_idx = 2'(n);
        bfound   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm          <= '0;
      live        <= NS'(1);
      thr_used    <= TW'(T_INIT);
      best_metric <= '0;
    end else if (step) begin
      pm          <= nm_adj;
      live        <= keep;
      thr_used    <= thr;
      best_metric <= nm_adj[best_idx];
    end
  end

  assign live_mask = live;

  avd_survivor #(.DEPTH(DEPTH)) u_surv (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .sel_hi   (sel_hi),
    .best_idx (best_idx),
    .out_valid(out_valid),
    .out_bit  (out_bit)
  );

  assert_survivor_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((live_mask != '0) && ($countones(live_mask) < NMAX)));

  assert_thr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((thr_used >= TW'(2)) && (thr_used <= TW'(T_INIT))));

  assert_no_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !shrink_evt) |=> (thr_used == TW'(T_INIT)));

  assert_cap_at_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cap_evt) |=> (thr_used == TW'(TFLOOR)));

  assert_metric_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (best_metric < MW'(2 ** (MW - 1) + T_INIT)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(live_mask) && $stable(best_metric) && !out_valid));
endmodule

// File: tb/avd_decoder_tb.sv
`timescale 1ns/1ps
module avd_decoder_tb;
  localparam int MW = 8, DEPTH = 15, NMAX = 3, T_INIT = 6, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] in_sym = 2'b00;
  logic out_valid, out_bit;
  logic [3:0] live_mask;
  logic [TW-1:0] thr_used;
  logic [MW-1:0] best_metric;

  always #4 clk = ~clk;

  avd_decoder #(.MW(MW), .DEPTH(DEPTH), .NMAX(NMAX), .T_INIT(T_INIT), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
    .out_valid(out_valid), .out_bit(out_bit), .live_mask(live_mask),
    .thr_used(thr_used), .best_metric(best_metric));

  int nchk = 0, nfail = 0;
  int mpm[4];
  bit mlive[4];
  int mpath[4];
  int mcnt;
  int e_live, e_thr, e_best, e_ov, e_ob;
  int n_norm = 0, n_cap = 0;
  int sent[$];
  int enc_a, enc_b;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin mpm[s] = 0; mlive[s] = 0; mpath[s] = 0; end
    mlive[0] = 1; mcnt = 0; enc_a = 0; enc_b = 0;
    sent.delete();
  endtask

  task automatic model_step(input logic [1:0] sym);
    int dmv, t, cnt, bi, nmv[4], pred[4], np[4];
    bit nvl[4], ps[4], kp[4], at_floor;
    dmv = 1 << 20;
    for (int s = 0; s < 4; s++) if (mlive[s] && mpm[s] < dmv) dmv = mpm[s];
    for (int n = 0; n < 4; n++) begin
      int u;
      u = n / 2; nvl[n] = 0; nmv[n] = 0; pred[n] = 0;
      for (int j = 0; j < 2; j++) begin
        int p, c1, c0, m;
        p = 2 * (n % 2) + j;
        if (mlive[p]) begin
          c1 = u ^ (p / 2) ^ (p % 2);
          c0 = u ^ (p % 2);
          m = mpm[p] + int'(c1 != int'(sym[1])) + int'(c0 != int'(sym[0]));
          if (m > 255) m = 255;
          if (!nvl[n] || m < nmv[n]) begin nmv[n] = m; pred[n] = p; nvl[n] = 1; end
        end
      end
    end
    t = T_INIT; at_floor = 0;
    while (1) begin
      cnt = 0;
      for (int n = 0; n < 4; n++) begin
        ps[n] = nvl[n] && (nmv[n] < dmv + t);
        cnt += int'(ps[n]);
      end
      if (cnt < NMAX) break;
      if (t - 2 < 2) begin at_floor = 1; break; end
      t -= 2;
    end
    for (int n = 0; n < 4; n++) kp[n] = at_floor ? 1'b0 : ps[n];
    if (at_floor) begin
      n_cap++;
      for (int r = 0; r < NMAX - 1; r++) begin
        bi = -1;
        for (int n = 0; n < 4; n++)
          if (ps[n] && !kp[n] && (bi < 0 || nmv[n] < nmv[bi])) bi = n;
        if (bi >= 0) kp[bi] = 1;
      end
    end
    if (dmv >= 128) begin
      n_norm++;
      for (int n = 0; n < 4; n++) nmv[n] -= dmv;
    end
    for (int n = 0; n < 4; n++) np[n] = ((mpath[pred[n]] << 1) | (n / 2)) & ((1 << DEPTH) - 1);
    bi = -1;
    for (int n = 0; n < 4; n++) if (kp[n] && (bi < 0 || nmv[n] < nmv[bi])) bi = n;
    e_live = 0;
    for (int n = 0; n < 4; n++) begin
      mpm[n] = nmv[n]; mlive[n] = kp[n]; mpath[n] = np[n];
      if (kp[n]) e_live |= (1 << n);
    end
    mcnt++;
    e_thr = t; e_best = nmv[bi];
    e_ov = int'(mcnt >= DEPTH);
    e_ob = (np[bi] >> (DEPTH - 1)) & 1;
  endtask

  // entered and left at a falling edge
  task automatic do_step(input logic [1:0] sym, input string req);
    model_step(sym);
    in_valid = 1'b1; in_sym = sym;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R3/R5/R7 live_mask"}, int'(live_mask), e_live);
    chk({req, " R4 thr_used"}, int'(thr_used), e_thr);
    chk({req, " R8 best_metric"}, int'(best_metric), e_best);
    chk({req, " R9 out_valid"}, int'(out_valid), e_ov);
    if (e_ov != 0) chk({req, " R9 out_bit"}, int'(out_bit), e_ob);
  endtask

  function automatic logic [1:0] encode(input int u);
    logic [1:0] s;
    s = {1'(u ^ enc_a ^ enc_b), 1'(u ^ enc_b)};
    enc_b = enc_a; enc_a = u;
    return s;
  endfunction

  task automatic idle_check();
    int l0, b0;
    l0 = int'(live_mask); b0 = int'(best_metric);
    in_sym = 2'($urandom_range(3));
    @(posedge clk);
    @(negedge clk);
    chk("R10 idle live_mask", int'(live_mask), l0);
    chk("R10 idle best_metric", int'(best_metric), b0);
    chk("R10 idle out_valid", int'(out_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk("R1 live_mask", int'(live_mask), 1);
    chk("R1 thr_used", int'(thr_used), T_INIT);
    chk("R1 best_metric", int'(best_metric), 0);
    chk("R1 out_valid", int'(out_valid), 0);
  endtask

  task automatic send_bit(input int u, input int flip, input string req);
    logic [1:0] s;
    s = encode(u);
    sent.push_back(u);
    do_step(s ^ 2'(flip), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(7));
    @(negedge clk);
    do_reset();

    // R2 / R4 hand-worked first steps
    send_bit(0, 0, "R2 first");
    chk("R2 pair 00 from reset live_mask", int'(live_mask), 5);
    chk("R4 no shrink needed thr", int'(thr_used), 6);
    send_bit(1, 0, "R2 second");
    chk("R4 shrink to floor live_mask", int'(live_mask), 4);
    chk("R4 shrink to floor thr", int'(thr_used), 2);
    chk("R6 best_metric", int'(best_metric), 0);

    // error-free stream with gaps; delayed-bit check for R9
    for (int i = 0; i < 220; i++) begin
      send_bit(int'($urandom_range(1)), 0, "clean");
      if (out_valid) chk("R9 clean delayed bit", int'(out_bit), sent[sent.size() - DEPTH]);
      if (i % 37 == 5) idle_check();
    end

    // isolated single bit errors (R6 merges exercised)
    do_reset();
    for (int i = 0; i < 200; i++)
      send_bit(int'($urandom_range(1)), (i % 19 == 9) ? (1 << (i % 2)) : 0, "R6 sparse errors");

    // random pairs: drives metrics up so rebasing and floor ranking meet
    do_reset();
    for (int i = 0; i < 420; i++) begin
      do_step(2'($urandom_range(3)), "noise");
      if (i % 50 == 7) idle_check();
    end
    chk("R8 rebasing exercised", int'(n_norm > 0), 1);
    chk("R5 floor ranking exercised", int'(n_cap > 0), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule